// File: doc/BRIEF.md
# Add/Subtract Unit with Latched Status Flags

This block is the arithmetic stage of a small microcoded 8-bit processor. It takes an accumulator value and an operand-register value and either adds them or adds the accumulator to the two's complement of the operand. The sum is built by a ripple of 4-bit adder slices. A single control line selects subtraction. It inverts the operand bits and also supplies the carry into the lowest slice. There is no reverse subtraction, no logic operation and no shift.

A second control gates the result onto the output. When it is low the output is zero. A third control captures four status bits into a register on a rising clock edge. These are carry, zero, negative and an overflow slot that is always zero. The controller uses the registered flags as part of its microcode address. The flags keep their value in every cycle where the capture control is low.

Top module: `addsub_flag_unit`

## Requirements
- R1: With `sub_en` low and `out_en` high, `result` equals (`op_a` + `op_b`) modulo 256.
- R2: With `sub_en` high and `out_en` high, `result` equals (`op_a` + (~`op_b`) + 1) modulo 256, which is `op_a` minus `op_b`.
- R3: With `out_en` low, `result` is 0 whatever the operands and mode.
- R4: The captured carry flag equals the carry out of the top slice of the adder chain. In subtract mode it is 1 exactly when `op_a` >= `op_b` taken as unsigned values.
- R5: The captured zero flag is 1 exactly when all eight bits of the sum are 0.
- R6: The captured negative flag equals bit 7 of the sum.
- R7: The overflow flag is always 0.
- R8: The flags take the new status values only on a rising clock edge where `flag_ld` is high. On every other edge they keep their previous value.
- R9: `rst_n` low at a rising clock edge clears all four flags to 0. The reset is synchronous and active-low.
- R10: `flags` is laid out as bit 3 = overflow, bit 2 = negative, bit 1 = zero, bit 0 = carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags are captured on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| op_a | input | 8 | Accumulator operand |
| op_b | input | 8 | Operand register value |
| sub_en | input | 1 | 1 selects op_a + two's complement of op_b |
| out_en | input | 1 | 1 drives the sum onto result, 0 forces result to 0 |
| flag_ld | input | 1 | 1 captures status into the flags register at the next rising edge |
| result | output | 8 | Gated sum |
| flags | output | 4 | Registered {overflow, negative, zero, carry} |

## Verification
The operand pairs cover several cases. Some additions stay below 256 and some wrap; these show whether the carry out of the upper slice is produced and dropped from the result. One addition of two values of 128 wraps exactly to zero, which tests that zero and carry can both be set at once. Subtractions with a larger, an equal and a smaller minuend separate the borrow sense of the carry and check the negative flag. Subtracting zero tests that the carry-in path alone produces a carry. Further directed steps change the operands while the capture control is low, so that a flag that fails to hold shows up. Another step drops the output enable. A reset taken mid-run must clear flags that were set.

// File: rtl/addsub_pkg.sv
// Shared types and widths for the add/subtract unit.
// Assumes a fixed four-bit status word whose order the controller decodes.
package addsub_pkg;
    localparam int FLAG_W = 4;

    // Status word, MSB first: overflow, negative, zero, carry (R10)
    typedef struct packed {
        logic ovf;
        logic neg;
        logic zero;
        logic carry;
    } flag_t;
endpackage

// File: rtl/nibble_adder.sv
// One ripple slice: adds two SLICE_W-bit values and a carry-in.
// Assumes the caller chains cout to the next slice's cin.
module nibble_adder #(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] a,
    input  logic [SLICE_W-1:0] b,
    input  logic               cin,
    output logic [SLICE_W-1:0] sum,
    output logic               cout
);
    logic [SLICE_W:0] total;

    // Full-width addition with the carry taken from the extra top bit
    always_comb begin
        total = {1'b0, a} + {1'b0, b} + {{SLICE_W{1'b0}}, cin};
        sum   = total[SLICE_W-1:0];
        cout  = total[SLICE_W];
    end
endmodule

// File: rtl/adder_chain.sv
// Ripple chain of adder slices performing a + b or a + ~b + 1.
// Assumes DATA_W is a multiple of SLICE_W. sub doubles as the chain carry-in.
module adder_chain #(
    parameter int DATA_W  = 8,
    parameter int SLICE_W = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);
    localparam int N_SLICE = DATA_W / SLICE_W;

    logic [DATA_W-1:0] b_eff;
    logic [N_SLICE:0]  carry;

    // Conditional inversion of the second operand and injection of the +1
    always_comb begin
        b_eff    = b ^ {DATA_W{sub}};
        carry[0] = sub;
    end

    for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
        nibble_adder #(.SLICE_W(SLICE_W)) u_slice (
            .a   (a[s*SLICE_W +: SLICE_W]),
            .b   (b_eff[s*SLICE_W +: SLICE_W]),
            .cin (carry[s]),
            .sum (sum[s*SLICE_W +: SLICE_W]),
            .cout(carry[s+1])
        );
    end

    assign cout = carry[N_SLICE];
endmodule

// File: rtl/flag_reg.sv
// Four-bit status register captured under a load control.
// Assumes synchronous active-low reset; holds when load is low.
module flag_reg
    import addsub_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  flag_t nxt,
    output flag_t q
);
    // Capture new status on a loaded edge, clear on reset, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= nxt;
    end

    AST_FLAG_RESET: assert property (@(posedge clk) !rst_n |=> q == '0); // R9
    AST_FLAG_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
                        !load |=> $stable(q)); // R8
    AST_FLAG_LOAD:  assert property (@(posedge clk) disable iff (!rst_n)
                        load |=> q == $past(nxt)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
                        q.ovf == 1'b0); // R7
endmodule

// File: rtl/addsub_flag_unit.sv
// Add/subtract unit: ripple adder, gated result, latched status flags.
// Assumes operands are stable around the rising edge when flags load.
module addsub_flag_unit
    import addsub_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SLICE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              sub_en,
    input  logic              out_en,
    input  logic              flag_ld,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags
);
    logic [DATA_W-1:0] sum;
    logic              cout;
    flag_t             status_nxt;
    flag_t             status_q;

    adder_chain #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_chain (
        .a   (op_a),
        .b   (op_b),
        .sub (sub_en),
        .sum (sum),
        .cout(cout)
    );

    // Derive status from the raw sum; overflow slot stays cleared
    always_comb begin
        status_nxt.ovf   = 1'b0;
        status_nxt.neg   = sum[DATA_W-1];
        status_nxt.zero  = (sum == '0);
        status_nxt.carry = cout;
    end

    flag_reg u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .load (flag_ld),
        .nxt  (status_nxt),
        .q    (status_q)
    );

    // Gate the sum onto the output
    assign result = out_en ? sum : '0;
    assign flags  = status_q;

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
                    !sub_en |-> {cout, sum} == ({1'b0, op_a} + {1'b0, op_b})); // R1
    AST_SUB_SUM: assert property (@(posedge clk) disable iff (!rst_n)
                    sub_en |-> {cout, sum} == ({1'b0, op_a} + {1'b0, ~op_b} + {{DATA_W{1'b0}}, 1'b1})); // R2
    AST_OE_LOW:  assert property (@(posedge clk) disable iff (!rst_n)
                    !out_en |-> result == '0); // R3
    AST_CARRY_LD: assert property (@(posedge clk) disable iff (!rst_n)
                    flag_ld |=> flags[0] == $past(cout)); // R4
endmodule

// File: tb/addsub_flag_unit_test.sv
module addsub_flag_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = '0, op_b = '0;
    logic       sub_en = 1'b0, out_en = 1'b0, flag_ld = 1'b0;
    logic [7:0] result;
    logic [3:0] flags;
    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    addsub_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .sub_en(sub_en), .out_en(out_en), .flag_ld(flag_ld),
        .result(result), .flags(flags)
    );

    // {sub, a, b}
    localparam int NV = 10;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 8'd3,   8'd5},    // R1 small add
        {1'b0, 8'd200, 8'd100},  // R1 R4 wrap with carry
        {1'b0, 8'd128, 8'd128},  // R5 wrap to zero, carry set
        {1'b0, 8'd0,   8'd0},    // R5 zero, no carry
        {1'b0, 8'd127, 8'd1},    // R6 R7 sign change, overflow stays 0
        {1'b1, 8'd10,  8'd3},    // R2 larger minuend
        {1'b1, 8'd3,   8'd10},   // R2 R4 R6 borrow, negative
        {1'b1, 8'd5,   8'd5},    // R2 R5 equal operands
        {1'b1, 8'd0,   8'd0},    // R4 carry-in alone gives carry
        {1'b1, 8'h80,  8'd1}     // R6 negative minus one
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] model_sum(input logic s, input logic [7:0] a, input logic [7:0] b);
        return s ? ({1'b0, a} + {1'b0, ~b} + 9'd1) : ({1'b0, a} + {1'b0, b});
    endfunction

    // R10 ordering: {ovf, neg, zero, carry}
    function automatic logic [3:0] model_flags(input logic [8:0] t);
        return {1'b0, t[7], (t[7:0] == 8'd0), t[8]};
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        logic [3:0] held;
        repeat (2) @(negedge clk);
        check("R9 reset flags", {4'd0, flags}, 8'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [8:0] t;
            @(negedge clk);
            {sub_en, op_a, op_b} = VEC[i];
            out_en = 1'b1; flag_ld = 1'b1;
            t = model_sum(sub_en, op_a, op_b);
            #2;
            check(sub_en ? "R2 result" : "R1 result", result, t[7:0]);
            @(negedge clk);
            flag_ld = 1'b0;
            check("R4 R5 R6 R10 flags", {4'd0, flags}, {4'd0, model_flags(t)});
            check("R7 overflow", {7'd0, flags[3]}, 8'd0);
        end

        // R8: change operands with load low; flags hold
        held = flags;
        @(negedge clk);
        sub_en = 1'b1; op_a = 8'd1; op_b = 8'd2; flag_ld = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 hold without load", {4'd0, flags}, {4'd0, held});

        // R8: now load, flags move
        flag_ld = 1'b1;
        @(negedge clk);
        flag_ld = 1'b0;
        check("R8 load", {4'd0, flags}, {4'd0, model_flags(model_sum(1'b1, 8'd1, 8'd2))});

        // R3: output disabled
        out_en = 1'b0; sub_en = 1'b0; op_a = 8'hA5; op_b = 8'h11;
        #2;
        check("R3 out_en low", result, 8'd0);

        // R9: reset mid-run clears set flags
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R9 mid-run reset", {4'd0, flags}, 8'd0);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule